// File: doc/BRIEF.md
# Dual-Bus Target Mode Detector

This block sits at the front of a serial-bus target that may find itself on either a legacy I2C bus or an I3C bus. It samples the raw clock and data lines and passes them through a synchronizer and a stability filter. It then spots START and STOP conditions and captures the first byte after each START: seven address bits and one direction bit.

Out of reset the target assumes a legacy bus. The stability filter stays on, because it suppresses short spikes in the fast and fast-plus legacy speed modes. The first header that carries the broadcast address 7'h7E moves the block into I3C mode. The move is permanent until the next reset. From then on the filter is bypassed, and clock stretching and legacy-only features are forced off.

A static-address configuration input tells the block whether the target owns a legacy address. Only with that input high, and only while still in legacy mode, does the block report the static address as usable and permit stretching and legacy-only features. Without a static address the target stays passive until the broadcast header arrives. The block has no streaming data path. All of its pins are plain control and status signals with no handshake.

Top module: `i3cmd_top`

## Requirements
- R1: After reset the block is in legacy mode: `i3c_mode_o`=0, `filt_en_o`=1, `switch_pulse_o`=0, and no header has been reported.
- R2: In legacy mode, a change on either line is accepted only after it has held for `STABLE_CYCLES` consecutive clock cycles. A 2-cycle spike on SCL is therefore not counted as a clock edge.
- R3: In I3C mode the filter is bypassed, and a 2-cycle SCL spike is counted as a clock edge.
- R4: A START is SDA falling while SCL is high. The next 8 SCL rising edges sample SDA, most significant bit first. The first 7 bits form `hdr_addr_o` and the 8th bit is `hdr_rw_o`. A single-cycle `hdr_valid_o` pulse then reports the header.
- R5: A START that arrives in the middle of a header restarts the bit count, so only the bits after the latest START are reported.
- R6: A header whose address is 7'h7E, received in legacy mode, sets `i3c_mode_o`=1 and `filt_en_o`=0. The direction bit makes no difference.
- R7: Headers with any other address leave the mode unchanged.
- R8: I3C mode is sticky: only reset clears it. `switch_pulse_o` fires for exactly one cycle, only on the transition, and later broadcast headers do not fire it again.
- R9: In legacy mode, `stretch_en_o`, `i2c_feat_en_o` and `static_ok_o` all equal `static_cfg_i`.
- R10: In I3C mode, `stretch_en_o`, `i2c_feat_en_o` and `static_ok_o` are 0 whatever `static_cfg_i` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line |
| static_cfg_i | input | 1 | Target has a legacy static address configured |
| filt_en_o | output | 1 | Spike filter enabled |
| stretch_en_o | output | 1 | Clock stretching permitted |
| i2c_feat_en_o | output | 1 | Legacy-only features permitted |
| static_ok_o | output | 1 | Static address may be used |
| i3c_mode_o | output | 1 | Block is in I3C mode |
| switch_pulse_o | output | 1 | One-cycle pulse on the switch to I3C mode |
| hdr_valid_o | output | 1 | Header captured (one cycle) |
| hdr_addr_o | output | 7 | Captured 7-bit address |
| hdr_rw_o | output | 1 | Captured direction bit |

## Verification
The bench injects a 2-cycle SCL spike in the middle of a broadcast header while in legacy mode. A filter that lets the spike through shifts in an extra bit, so the address comes out as 7'h7F and the mode never switches. The same spike is injected again once in I3C mode, where the captured address must show the extra shifted bit; a filter left on would report the clean address instead. A START inserted part-way through a header must discard the partial bits, or the reported address comes out shifted. Random non-broadcast headers with a random static-address setting check that the mode holds and the permission outputs follow the configuration. Repeated broadcast headers after the switch must not pulse `switch_pulse_o` a second time.

// File: rtl/i3cmd_pkg.sv
package i3cmd_pkg;
  localparam int HDR_BITS = 8;
  localparam logic [6:0] BCAST_ADDR = 7'h7E;
  typedef enum logic [0:0] {HS_IDLE, HS_SHIFT} hdr_state_t;
endpackage

// File: rtl/i3cmd_glitch_filter.sv
module i3cmd_glitch_filter #(
  parameter int SYNC_STAGES   = 2,
  parameter int STABLE_CYCLES = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic bypass,
  output logic dout
);
  localparam int CW = $clog2(STABLE_CYCLES + 1);

  logic [SYNC_STAGES-1:0] sreg;
  logic                   s;
  logic [CW-1:0]          cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sreg <= '1;
    else        sreg <= {sreg[SYNC_STAGES-2:0], din};
  end
  assign s = sreg[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= 1'b1;
      cnt  <= '0;
    end else if (bypass) begin
      dout <= s;
      cnt  <= '0;
    end else if (s == dout) begin
      cnt <= '0;
    end else if (cnt == CW'(STABLE_CYCLES - 1)) begin
      dout <= s;
      cnt  <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R2: a freshly seen mismatch never reaches the output on the next cycle
  p_new_change_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && (s != dout) && (cnt == '0)) |=> (bypass || $stable(dout)));
endmodule

// File: rtl/i3cmd_hdr_capture.sv
module i3cmd_hdr_capture
  import i3cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl,
  input  logic       sda,
  output logic       hdr_valid,
  output logic [6:0] hdr_addr,
  output logic       hdr_rw
);
  localparam int BW = $clog2(HDR_BITS);

  hdr_state_t           state;
  logic                 scl_q, sda_q;
  logic                 start_det, stop_det, scl_rise;
  logic [BW-1:0]        bit_cnt;
  logic [HDR_BITS-2:0]  shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign start_det = scl && scl_q && sda_q && !sda;
  assign stop_det  = scl && scl_q && !sda_q && sda;
  assign scl_rise  = scl && !scl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= HS_IDLE;
      bit_cnt   <= '0;
      shreg     <= '0;
      hdr_valid <= 1'b0;
      hdr_addr  <= '0;
      hdr_rw    <= 1'b0;
    end else begin
      hdr_valid <= 1'b0;
      if (start_det) begin
        state   <= HS_SHIFT;
        bit_cnt <= '0;
      end else if (stop_det) begin
        state <= HS_IDLE;
      end else if (state == HS_SHIFT && scl_rise) begin
        if (bit_cnt == BW'(HDR_BITS - 1)) begin
          hdr_addr  <= shreg;
          hdr_rw    <= sda;
          hdr_valid <= 1'b1;
          state     <= HS_IDLE;
        end else begin
          shreg   <= {shreg[HDR_BITS-3:0], sda};
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  // R4: a header report lasts one cycle
  p_valid_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |=> !hdr_valid);
  // R5: every START restarts capture from bit zero
  p_start_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == HS_SHIFT && bit_cnt == '0));
endmodule

// File: rtl/i3cmd_mode_ctrl.sv
module i3cmd_mode_ctrl
  import i3cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hdr_valid,
  input  logic [6:0] hdr_addr,
  input  logic       static_cfg,
  output logic       i3c_mode,
  output logic       switch_pulse,
  output logic       filt_en,
  output logic       stretch_en,
  output logic       feat_en,
  output logic       static_ok
);
  logic bcast_seen;
  assign bcast_seen = hdr_valid && (hdr_addr == BCAST_ADDR) && !i3c_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i3c_mode     <= 1'b0;
      switch_pulse <= 1'b0;
    end else begin
      switch_pulse <= bcast_seen;
      if (bcast_seen) i3c_mode <= 1'b1;
    end
  end

  assign filt_en    = !i3c_mode;
  assign static_ok  = !i3c_mode && static_cfg;
  assign stretch_en = static_ok;
  assign feat_en    = static_ok;

  // R8: once in I3C mode, stay there
  p_mode_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    i3c_mode |=> i3c_mode);
  // R8: pulse only on the switching edge
  p_pulse_on_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    switch_pulse |-> (i3c_mode && !$past(i3c_mode)));
  // R6: broadcast header in legacy mode switches modes
  p_bcast_switch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && hdr_addr == BCAST_ADDR) |=> i3c_mode);
  // R10: no legacy permissions in I3C mode
  p_no_legacy_perm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    i3c_mode |-> (!stretch_en && !feat_en && !static_ok));
endmodule

// File: rtl/i3cmd_top.sv
module i3cmd_top #(
  parameter int SYNC_STAGES   = 2,
  parameter int STABLE_CYCLES = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       static_cfg_i,
  output logic       filt_en_o,
  output logic       stretch_en_o,
  output logic       i2c_feat_en_o,
  output logic       static_ok_o,
  output logic       i3c_mode_o,
  output logic       switch_pulse_o,
  output logic       hdr_valid_o,
  output logic [6:0] hdr_addr_o,
  output logic       hdr_rw_o
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_lines, clean_lines;
  logic              filt_en;

  assign raw_lines = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    i3cmd_glitch_filter #(
      .SYNC_STAGES  (SYNC_STAGES),
      .STABLE_CYCLES(STABLE_CYCLES)
    ) i_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (raw_lines[g]),
      .bypass(!filt_en),
      .dout  (clean_lines[g])
    );
  end

  i3cmd_hdr_capture i_hdr (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl      (clean_lines[1]),
    .sda      (clean_lines[0]),
    .hdr_valid(hdr_valid_o),
    .hdr_addr (hdr_addr_o),
    .hdr_rw   (hdr_rw_o)
  );

  i3cmd_mode_ctrl i_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .hdr_valid   (hdr_valid_o),
    .hdr_addr    (hdr_addr_o),
    .static_cfg  (static_cfg_i),
    .i3c_mode    (i3c_mode_o),
    .switch_pulse(switch_pulse_o),
    .filt_en     (filt_en),
    .stretch_en  (stretch_en_o),
    .feat_en     (i2c_feat_en_o),
    .static_ok   (static_ok_o)
  );

  assign filt_en_o = filt_en;

  // R3: filter is never on while in I3C mode
  p_filter_off_i3c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    i3c_mode_o |-> !filt_en_o);
endmodule

// File: tb/test_i3cmd_top.sv
module test_i3cmd_top;
  localparam int H = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1, cfg = 1'b0;
  logic filt_en, stretch_en, feat_en, static_ok, i3c_mode, pulse, hdr_valid, hdr_rw;
  logic [6:0] hdr_addr;

  int checks = 0, errors = 0;
  int hdr_cnt = 0, pulse_cnt = 0;
  logic [6:0] last_addr = '0;
  logic       last_rw = 1'b0;
  bit done = 0;

  always #5 clk = ~clk;

  i3cmd_top i_i3cmd_top (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .static_cfg_i(cfg),
    .filt_en_o(filt_en), .stretch_en_o(stretch_en), .i2c_feat_en_o(feat_en),
    .static_ok_o(static_ok), .i3c_mode_o(i3c_mode), .switch_pulse_o(pulse),
    .hdr_valid_o(hdr_valid), .hdr_addr_o(hdr_addr), .hdr_rw_o(hdr_rw)
  );

  always @(negedge clk) begin
    if (rst_n && hdr_valid) begin
      hdr_cnt++;
      last_addr = hdr_addr;
      last_rw   = hdr_rw;
    end
    if (rst_n && pulse) pulse_cnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    sda = 1'b1; scl = 1'b1; waitc(H);
    sda = 1'b0; waitc(H);
    scl = 1'b0; waitc(H);
  endtask

  task automatic do_stop();
    sda = 1'b0; waitc(H);
    scl = 1'b1; waitc(H);
    sda = 1'b1; waitc(H);
  endtask

  task automatic do_bit(input logic b);
    sda = b; waitc(H);
    scl = 1'b1; waitc(H);
    scl = 1'b0;
  endtask

  task automatic send_bits(input logic [6:0] a, input logic rw);
    for (int i = 6; i >= 0; i--) do_bit(a[i]);
    do_bit(rw);
    do_bit(1'b1);
    do_stop();
  endtask

  task automatic send_hdr(input logic [6:0] a, input logic rw);
    do_start();
    send_bits(a, rw);
  endtask

  // START, then a 2-cycle SCL spike with SDA high, then a full header
  task automatic spike_hdr(input logic [6:0] a, input logic rw);
    do_start();
    sda = 1'b1; waitc(H / 2);
    scl = 1'b1; waitc(2);
    scl = 1'b0; waitc(H / 2);
    send_bits(a, rw);
  endtask

  function automatic logic exp_perm(input logic legacy, input logic c);
    return legacy && c;
  endfunction

  initial begin
    waitc(200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n0;
    logic [6:0] ra;
    logic rrw, rc;
    void'($urandom(32'd1234));
    waitc(4);
    rst_n = 1'b1;
    waitc(4);
    // R1 reset state
    chk("R1 mode", i3c_mode, 0);
    chk("R1 filter", filt_en, 1);
    chk("R1 pulse", pulse_cnt, 0);
    chk("R1 hdr", hdr_cnt, 0);
    // R9 permissions follow the static configuration in legacy mode
    cfg = 1'b1; waitc(2);
    chk("R9 stretch", stretch_en, 1);
    chk("R9 feat", feat_en, 1);
    chk("R9 static", static_ok, 1);
    cfg = 1'b0; waitc(2);
    chk("R9 stretch off", stretch_en, 0);
    chk("R9 static off", static_ok, 0);
    // R4 directed header
    n0 = hdr_cnt;
    send_hdr(7'h3C, 1'b1);
    chk("R4 count", hdr_cnt - n0, 1);
    chk("R4 addr", last_addr, 7'h3C);
    chk("R4 rw", last_rw, 1);
    chk("R7 mode", i3c_mode, 0);
    // R5 restart mid-header
    n0 = hdr_cnt;
    do_start();
    do_bit(1'b1); do_bit(1'b0); do_bit(1'b1);
    send_hdr(7'h12, 1'b0);
    chk("R5 count", hdr_cnt - n0, 1);
    chk("R5 addr", last_addr, 7'h12);
    chk("R5 rw", last_rw, 0);
    // R7 / R9 random legacy traffic
    for (int k = 0; k < 20; k++) begin
      ra  = 7'($urandom % 128);
      if (ra == 7'h7E) ra = 7'h7D;
      rrw = 1'($urandom % 2);
      rc  = 1'($urandom % 2);
      cfg = rc;
      send_hdr(ra, rrw);
      chk("R4 rand addr", last_addr, ra);
      chk("R4 rand rw", last_rw, rrw);
      chk("R7 rand mode", i3c_mode, 0);
      chk("R9 rand stretch", stretch_en, exp_perm(1'b1, rc));
      chk("R9 rand feat", feat_en, exp_perm(1'b1, rc));
    end
    cfg = 1'b0;
    chk("R8 no pulse yet", pulse_cnt, 0);
    // R2 legacy spike is filtered; R6 broadcast switches
    spike_hdr(7'h7E, 1'b0);
    chk("R2 addr", last_addr, 7'h7E);
    chk("R6 mode", i3c_mode, 1);
    chk("R6 filter off", filt_en, 0);
    chk("R8 one pulse", pulse_cnt, 1);
    // R10 legacy permissions blocked
    cfg = 1'b1; waitc(2);
    chk("R10 stretch", stretch_en, 0);
    chk("R10 feat", feat_en, 0);
    chk("R10 static", static_ok, 0);
    // R3 spike passes in I3C mode: extra leading 1 shifts 0101010_1 to 1010101_0
    spike_hdr(7'h2A, 1'b1);
    chk("R3 addr", last_addr, 7'h55);
    chk("R3 rw", last_rw, 0);
    // R8 sticky, no further pulses
    send_hdr(7'h7E, 1'b1);
    for (int k = 0; k < 5; k++) begin
      ra = 7'($urandom % 128);
      send_hdr(ra, 1'b0);
      chk("R8 sticky", i3c_mode, 1);
      chk("R10 rand stretch", stretch_en, 0);
    end
    chk("R8 pulse count", pulse_cnt, 1);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule